// File: doc/BRIEF.md
# Conveyor Log Length Classifier

This block watches two presence sensors mounted one after the other along a conveyor and decides, for each log that passes, whether it is long or short. A log is long if it covers both sensors together at some point; a short log never does. Once a long log has been seen and its trailing end has cleared the downstream sensor, the block raises a cut strobe for exactly one clock cycle. External logic uses that strobe to pause the belt and run the saw.

The controller is a Mealy machine with three reachable states: idle, upstream-covered and both-covered. The cut strobe is decoded from the present state and the live sensor inputs, so it rises in the same cycle that both sensors read low after a long log. Sensor patterns that cannot happen on a real belt in a given state send the machine back to idle, and so does the one unused state code. Only logs are expected on the belt, one at a time, with gaps between them.

Top module: `log_cut_ctrl`

## Requirements
- R1: While the synchronous active-high reset is high, the cut strobe is low; on the clock edge where reset is sampled high the state becomes idle (code 00).
- R2: In idle, only the pattern upstream-high/downstream-low moves to the upstream-covered state (code 01); every other pattern keeps the machine idle.
- R3: In the upstream-covered state, upstream-only keeps the state and both-high moves to the both-covered state (code 10).
- R4: In the upstream-covered state, both-low or downstream-only returns to idle without a cut.
- R5: In the both-covered state, downstream-only or both-high keeps the state.
- R6: In the both-covered state, upstream-only is impossible and returns to idle with no cut; the unused code 11 also returns to idle with the strobe low.
- R7: In the both-covered state with both sensors low, the cut strobe is high in that same cycle and the next state is idle.
- R8: The cut strobe never stays high for two consecutive cycles.
- R9: A log that never covers both sensors at once never produces a cut strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sens_up | input | 1 | Upstream sensor, high while a log is beneath it |
| sens_dn | input | 1 | Downstream sensor, high while a log is beneath it |
| cut | output | 1 | One-cycle cut command |

## Verification
Long logs are driven with several exit profiles: leaving through a downstream-only phase, alternating between both-covered and downstream-only, and dropping straight from both-covered to both-low, which together separate a correct hold in the both-covered state from an early or missing cut. Short logs that leave via both-low or via downstream-only confirm that no strobe is produced without overlap. Impossible patterns from idle and from the both-covered state, each followed by a both-low cycle, reveal through the strobe whether the machine truly fell back to idle. Back-to-back long logs and a reset landing mid-log show that the strobe is a single cycle and that reset clears a pending cut.

// File: rtl/log_cut_pkg.sv
package log_cut_pkg;
   localparam int STAGE_W = 2;

   typedef enum logic [STAGE_W-1:0] {
      ST_IDLE  = 2'b00,
      ST_ARM   = 2'b01,
      ST_LONG  = 2'b10,
      ST_SPARE = 2'b11
   } stage_t;

   typedef struct packed {
      logic up;
      logic dn;
   } sense_t;
endpackage

// File: rtl/lc_next.sv
module lc_next
   import log_cut_pkg::*;
(
   input  stage_t cur,
   input  sense_t sns,
   output stage_t nxt
);
   always_comb begin
      nxt = ST_IDLE;
      unique case (cur)
         ST_IDLE: begin
            if (sns.up && !sns.dn) nxt = ST_ARM;
         end
         ST_ARM: begin
            if (sns.up && !sns.dn)     nxt = ST_ARM;
            else if (sns.up && sns.dn) nxt = ST_LONG;
         end
         ST_LONG: begin
            if (sns.dn) nxt = ST_LONG;
         end
         default: nxt = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/lc_state_reg.sv
module lc_state_reg
   import log_cut_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  stage_t nxt,
   output stage_t cur
);
   always_ff @(posedge clk) begin
      if (rst) cur <= ST_IDLE;
      else     cur <= nxt;
   end
endmodule

// File: rtl/lc_cut_decode.sv
module lc_cut_decode
   import log_cut_pkg::*;
(
   input  logic   rst,
   input  stage_t cur,
   input  sense_t sns,
   output logic   cut
);
   always_comb begin
      cut = (cur == ST_LONG) && !sns.up && !sns.dn && !rst;
   end
endmodule

// File: rtl/log_cut_ctrl.sv
module log_cut_ctrl
   import log_cut_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic sens_up,
   input  logic sens_dn,
   output logic cut
);
   sense_t sns;
   stage_t cur_state;
   stage_t nxt_state;

   initial begin
      if (STAGE_W < 2) $error("log_cut_ctrl: state width too small");
   end

   assign sns.up = sens_up;
   assign sns.dn = sens_dn;

   lc_next u_next (
      .cur (cur_state),
      .sns (sns),
      .nxt (nxt_state)
   );

   lc_state_reg u_reg (
      .clk (clk),
      .rst (rst),
      .nxt (nxt_state),
      .cur (cur_state)
   );

   lc_cut_decode u_dec (
      .rst (rst),
      .cur (cur_state),
      .sns (sns),
      .cut (cut)
   );
endmodule

// File: rtl/lc_check.sv
module lc_check (
   input logic       clk,
   input logic       rst,
   input logic       sens_up,
   input logic       sens_dn,
   input logic       cut,
   input logic [1:0] cur
);
   always_comb begin
      if (rst) assert_reset_quiet_R1: assert (!cut);
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> cur == 2'b00);

   assert_idle_arm_R2: assert property (@(posedge clk) disable iff (rst)
      (cur == 2'b00 && sens_up && !sens_dn) |=> cur == 2'b01);

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (cur == 2'b00 && !(sens_up && !sens_dn)) |=> cur == 2'b00);

   assert_arm_long_R3: assert property (@(posedge clk) disable iff (rst)
      (cur == 2'b01 && sens_up && sens_dn) |=> cur == 2'b10);

   assert_arm_drop_R4: assert property (@(posedge clk) disable iff (rst)
      (cur == 2'b01 && !sens_up) |=> (cur == 2'b00 && !cut));

   assert_long_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (cur == 2'b10 && sens_dn) |=> cur == 2'b10);

   assert_long_abort_R6: assert property (@(posedge clk) disable iff (rst)
      (cur == 2'b10 && sens_up && !sens_dn) |=> cur == 2'b00);

   assert_spare_R6: assert property (@(posedge clk) disable iff (rst)
      (cur == 2'b11) |=> cur == 2'b00);

   assert_cut_when_R7: assert property (@(posedge clk) disable iff (rst)
      cut |-> (!sens_up && !sens_dn));

   assert_cut_next_R7: assert property (@(posedge clk) disable iff (rst)
      cut |=> cur == 2'b00);

   assert_cut_single_R8: assert property (@(posedge clk) disable iff (rst)
      cut |=> !cut);
endmodule

bind log_cut_ctrl lc_check u_chk (
   .clk     (clk),
   .rst     (rst),
   .sens_up (sens_up),
   .sens_dn (sens_dn),
   .cut     (cut),
   .cur     (cur_state)
);

// File: tb/sim_log_cut_ctrl.sv
module sim_log_cut_ctrl;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic up  = 1'b0;
   logic dn  = 1'b0;
   logic cut;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   log_cut_ctrl u0 (
      .clk     (clk),
      .rst     (rst),
      .sens_up (up),
      .sens_dn (dn),
      .cut     (cut)
   );

   task automatic step(input logic r, input logic u, input logic d,
                       input bit e, input string tag);
      @(negedge clk);
      rst = r; up = u; dn = d;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor: samples 2 ns before each rising edge
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (cut !== e) begin
               bad++;
               $display("FAIL %s: cut=%b expected=%b", t, cut, e);
            end
         end
      end
   end

   initial begin
      #100000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run hung");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 reset, strobe low
      step(1, 0, 0, 0, "R1 reset low");
      step(1, 1, 1, 0, "R1 reset both high");
      // R2 idle ignores downstream-only and both-high
      step(0, 0, 1, 0, "R2 idle dn-only");
      step(0, 1, 1, 0, "R2 idle both");
      step(0, 0, 0, 0, "R2 stayed idle");
      // long log, downstream-only exit
      step(0, 1, 0, 0, "R2 arm");
      step(0, 1, 0, 0, "R3 arm hold");
      step(0, 1, 1, 0, "R3 to long");
      step(0, 1, 1, 0, "R5 both hold");
      step(0, 0, 1, 0, "R5 dn hold");
      step(0, 0, 1, 0, "R5 dn hold 2");
      step(0, 0, 0, 1, "R7 cut");
      step(0, 0, 0, 0, "R8 single cycle");
      // short log leaving via both-low
      step(0, 1, 0, 0, "R9 short arm");
      step(0, 0, 0, 0, "R4 drop both-low");
      step(0, 0, 0, 0, "R9 no cut");
      // short log leaving via downstream-only
      step(0, 1, 0, 0, "R9 short arm 2");
      step(0, 0, 1, 0, "R4 drop dn-only");
      step(0, 0, 1, 0, "R2 idle dn-only again");
      step(0, 0, 0, 0, "R9 no cut 2");
      // impossible from long
      step(0, 1, 0, 0, "R6 arm");
      step(0, 1, 1, 0, "R6 long");
      step(0, 1, 0, 0, "R6 up-only abort");
      step(0, 0, 0, 0, "R6 back in idle");
      // alternating long hold
      step(0, 1, 0, 0, "R5 arm");
      step(0, 1, 1, 0, "R5 long");
      step(0, 0, 1, 0, "R5 alt dn");
      step(0, 1, 1, 0, "R5 alt both");
      step(0, 0, 1, 0, "R5 alt dn 2");
      step(0, 0, 0, 1, "R7 cut alt");
      // back to back, direct drop from both-high
      step(0, 1, 0, 0, "R7 b2b arm");
      step(0, 1, 1, 0, "R7 b2b long");
      step(0, 0, 0, 1, "R7 direct cut");
      step(0, 1, 0, 0, "R8 rearm right after cut");
      step(0, 1, 1, 0, "R8 long again");
      step(0, 0, 1, 0, "R8 dn");
      step(0, 0, 0, 1, "R7 second cut");
      step(0, 0, 0, 0, "R8 low after second cut");
      // reset mid-log clears pending cut
      step(0, 1, 0, 0, "R1 arm before reset");
      step(0, 1, 1, 0, "R1 long before reset");
      step(1, 0, 0, 0, "R1 reset masks cut");
      step(0, 0, 0, 0, "R1 idle after reset");
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         bad++;
         total++;
         $display("FAIL scoreboard: %0d pending, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule